// File: doc/BRIEF.md
# Interrupt Status and Mask Bank

This block gathers single-cycle event pulses from a serial-bus transfer engine into a sticky status register and folds them onto one interrupt request line through a hidden enable mask. Ten event positions are defined: transfer done (0), data threshold reached (1), address or data not acknowledged (2), timeout (3), target ready (4), receive overrun (5), transmit overrun (6), receive underrun (7), and arbitration lost (9). Position 8 is reserved and never holds a one.

Software reaches the bank over a simple register bus with write and read strobes, a 4-bit word offset and 32-bit data. The status register is read at word offset 4 (byte 0x10), and writing back a value that was read clears exactly the bits that were ones (write-one-to-clear). The mask cannot be written directly. A write to word offset 9 (byte 0x24) sets the mask bits that are ones in the data, and a write to word offset 10 (byte 0x28) clears them. The mask is read at word offset 8 (byte 0x20). A second registered output flags any pending error-class event: not acknowledged, receive overrun, transmit overrun, receive underrun or arbitration lost.

Top module: `irq_status_bank`

## Requirements
- R1: After reset, status and mask read zero, and both `irq_req` and `err_pending` are low.
- R2: An event pulse on bit i sets status bit i, which stays set once the pulse ends until software clears it.
- R3: A write to word offset 4 clears the status bits that are one in `bus_wdata[9:0]` and leaves all other status bits unchanged.
- R4: If an event pulse arrives in the same cycle as a clearing write to that bit, the status bit stays set.
- R5: A write to word offset 9 sets the mask bits that are one in `bus_wdata[9:0]`. The mask reads back at word offset 8, and a 1 enables the source.
- R6: A write to word offset 10 clears the mask bits that are one in `bus_wdata[9:0]` and leaves the other mask bits unchanged.
- R7: `irq_req` equals the OR of (status AND mask) as it stood one clock earlier.
- R8: Reads of word offsets 9 and 10, and of every offset other than 4 and 8, return zero.
- R9: Bit 8 and bits 31..10 always read zero in status and mask, even after writes or pulses with those bits set.
- R10: `err_pending` equals the OR of the status bits 9, 7, 6, 5 and 2 as they stood one clock earlier, and does not depend on the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when `bus_rd` is low |
| evt_pulse | input | 10 | Event pulses from the transfer engine |
| irq_req | output | 1 | Registered interrupt request |
| err_pending | output | 1 | Registered error-class pending flag |

## Verification
The bench builds the bank with its default sizes: 10 event bits, a 4-bit word offset and a 32-bit data bus. At these sizes every single event bit, every offset of the address space and 32 computed clear and mask patterns can be swept one after another. A bench model of status and mask predicts each readback and the interrupt and error outputs one cycle after each change. The same-cycle pulse-and-clear collision, the reserved bit 8 and the unmapped offsets are all within the sweep.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    localparam int EVT_W = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    // event positions (decoded by software, so fixed)
    localparam int EV_DONE    = 0;
    localparam int EV_THRESH  = 1;
    localparam int EV_NOACK   = 2;
    localparam int EV_TIMEOUT = 3;
    localparam int EV_TGT_RDY = 4;
    localparam int EV_RX_OVR  = 5;
    localparam int EV_TX_OVR  = 6;
    localparam int EV_RX_UNR  = 7;
    localparam int EV_ARB     = 9;

    localparam logic [EVT_W-1:0] EVT_USED =
        EVT_W'((1 << EV_DONE) | (1 << EV_THRESH) | (1 << EV_NOACK) |
               (1 << EV_TIMEOUT) | (1 << EV_TGT_RDY) | (1 << EV_RX_OVR) |
               (1 << EV_TX_OVR) | (1 << EV_RX_UNR) | (1 << EV_ARB));

    localparam logic [EVT_W-1:0] EVT_ERRS =
        EVT_W'((1 << EV_NOACK) | (1 << EV_RX_OVR) | (1 << EV_TX_OVR) |
               (1 << EV_RX_UNR) | (1 << EV_ARB));

    // word offsets
    localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_MASK   = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFS_SET    = ADDR_W'(9);
    localparam logic [ADDR_W-1:0] OFS_CLR    = ADDR_W'(10);
endpackage

// File: rtl/irq_sticky_status.sv
module irq_sticky_status #(
    parameter int W = 10,
    parameter logic [W-1:0] USED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] status_q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr_en) nxt_d.bits = nxt_d.bits & ~clr_bits;
        // a new pulse wins over a clear in the same cycle
        nxt_d.bits = (nxt_d.bits | evt) & USED;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign status_q = cur_q.bits;

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((status_q & $past(status_q)) == $past(status_q)));

    assert_pulse_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(evt) & USED) == ($past(evt) & USED)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((status_q & $past(clr_bits) & ~$past(evt)) == '0));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int W = 10,
    parameter logic [W-1:0] USED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic [W-1:0] set_bits,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] mask_q
);
    typedef struct packed {
        logic [W-1:0] en;
    } mk_t;

    mk_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (set_en) nxt_d.en = nxt_d.en | (set_bits & USED);
        if (clr_en) nxt_d.en = nxt_d.en & ~clr_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign mask_q = cur_q.en;

    assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en) |=>
            ((mask_q & $past(set_bits) & USED) == ($past(set_bits) & USED)));

    assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((mask_q & $past(clr_bits)) == '0));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(mask_q));
endmodule

// File: rtl/irq_req_out.sv
module irq_req_out #(
    parameter int W = 10,
    parameter logic [W-1:0] ERRS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status,
    input  logic [W-1:0] mask,
    output logic         irq_q,
    output logic         err_q
);
    typedef struct packed {
        logic irq;
        logic err;
    } rq_t;

    rq_t cur_q, nxt_d;

    always_comb begin
        nxt_d.irq = |(status & mask);
        nxt_d.err = |(status & ERRS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign irq_q = cur_q.irq;
    assign err_q = cur_q.err;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_bank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [EVT_W-1:0] evt_pulse,
    output logic          irq_req,
    output logic          err_pending
);
    localparam int PAD = DW - EVT_W;

    logic [EVT_W-1:0] status_w, mask_w, wbits;
    logic wr_status, wr_set, wr_clr;

    assign wbits     = bus_wdata[EVT_W-1:0];
    assign wr_status = bus_wr && (bus_addr == AW'(OFS_STATUS));
    assign wr_set    = bus_wr && (bus_addr == AW'(OFS_SET));
    assign wr_clr    = bus_wr && (bus_addr == AW'(OFS_CLR));

    irq_sticky_status #(.W(EVT_W), .USED(EVT_USED)) u_status (
        .clk(clk), .rst_n(rst_n), .evt(evt_pulse),
        .clr_en(wr_status), .clr_bits(wbits), .status_q(status_w));

    irq_mask_bank #(.W(EVT_W), .USED(EVT_USED)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_en(wr_set), .set_bits(wbits),
        .clr_en(wr_clr), .clr_bits(wbits), .mask_q(mask_w));

    irq_req_out #(.W(EVT_W), .ERRS(EVT_ERRS)) u_req (
        .clk(clk), .rst_n(rst_n), .status(status_w), .mask(mask_w),
        .irq_q(irq_req), .err_q(err_pending));

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == AW'(OFS_STATUS))    bus_rdata = {{PAD{1'b0}}, status_w};
            else if (bus_addr == AW'(OFS_MASK)) bus_rdata = {{PAD{1'b0}}, mask_w};
        end
    end

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_req == $past(|(status_w & mask_w))));

    assert_err_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_pending == $past(|(status_w & EVT_ERRS))));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_rdata[DW-1:EVT_W] == '0 && bus_rdata[8] == 1'b0));

    assert_wo_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != AW'(OFS_STATUS) && bus_addr != AW'(OFS_MASK))
            |-> (bus_rdata == '0));
endmodule

// File: tb/tb_irq_status_bank.sv
module tb_irq_status_bank;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] USED = 10'h2FF;
    localparam logic [9:0] ERRS = 10'h2E4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0] evt_pulse = '0;
    logic irq_req, err_pending;

    int errors = 0, checks = 0;
    logic [9:0] m_status = '0, m_mask = '0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .irq_req(irq_req), .err_pending(err_pending));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [9:0] ev);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_pulse = ev;
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse = '0;
    endtask

    task automatic pulse(input logic [9:0] ev);
        @(negedge clk);
        evt_pulse = ev;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle_check_outputs(input string req);
        @(negedge clk);
        chk(req, {31'b0, irq_req}, {31'b0, |(m_status & m_mask)});
        chk("R10", {31'b0, err_pending}, {31'b0, |(m_status & ERRS)});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd4, rv); chk("R1 status", rv, 0);
        rd(4'd8, rv); chk("R1 mask", rv, 0);
        chk("R1 irq", {31'b0, irq_req}, 0);
        chk("R1 err", {31'b0, err_pending}, 0);

        // R2 each event bit sets and sticks; R10 err group per bit, mask off
        for (int i = 0; i < 10; i++) begin
            pulse(10'(1 << i));
            m_status = (m_status | 10'(1 << i)) & USED;
            rd(4'd4, rv); chk("R2 set", rv, {22'b0, m_status});
            idle_check_outputs("R7");
            rd(4'd4, rv); chk("R2 sticky", rv, {22'b0, m_status});
            wr(4'd4, 32'h3FF, '0); m_status = '0;
            idle_check_outputs("R10 clear");
        end

        // R5 enable single bits, R7 irq with one pending event
        for (int i = 0; i < 10; i++) begin
            wr(4'd9, 32'(1 << i), '0); m_mask = (m_mask | 10'(1 << i)) & USED;
            rd(4'd8, rv); chk("R5 mask", rv, {22'b0, m_mask});
            pulse(10'(1 << i)); m_status = (m_status | 10'(1 << i)) & USED;
            idle_check_outputs("R7 irq");
            wr(4'd4, 32'(1 << i), '0); m_status = m_status & ~10'(1 << i);
            idle_check_outputs("R7 drop");
        end

        // R3 / R6 / R9 computed patterns
        for (int p = 0; p < 32; p++) begin
            logic [31:0] pat;
            pat = (32'(p) * 32'd37 + 32'd11) ^ (32'(p) << 5) ^ 32'hFFFF_F000;
            pulse(10'h3FF); m_status = USED;
            wr(4'd4, pat, '0); m_status = m_status & ~pat[9:0];
            rd(4'd4, rv); chk("R3 w1c", rv, {22'b0, m_status});
            wr(4'd10, pat, '0); m_mask = m_mask & ~pat[9:0];
            rd(4'd8, rv); chk("R6 disable", rv, {22'b0, m_mask});
            idle_check_outputs("R7 pat");
            wr(4'd9, ~pat, '0); m_mask = (m_mask | ~pat[9:0]) & USED;
            rd(4'd8, rv); chk("R9 mask bits", rv, {22'b0, m_mask});
        end

        // R4 pulse and clear in the same cycle
        pulse(10'h3FF); m_status = USED;
        wr(4'd4, 32'h3FF, 10'h021); m_status = 10'h021;
        rd(4'd4, rv); chk("R4 collide", rv, {22'b0, m_status});
        idle_check_outputs("R7 collide");

        // R9 write attempts on reserved positions
        wr(4'd4, 32'hFFFF_FFFF, 10'h100); m_status = '0;
        rd(4'd4, rv); chk("R9 status bit8", rv, 0);
        wr(4'd10, 32'hFFFF_FFFF, '0); m_mask = '0;
        wr(4'd9, 32'hFFFF_FFFF, '0); m_mask = USED;
        rd(4'd8, rv); chk("R9 mask bit8", rv, {22'b0, USED});

        // R8 every offset other than 4 and 8 reads zero
        pulse(10'h3FF); m_status = USED;
        for (int a = 0; a < 16; a++) begin
            if (a != 4 && a != 8) begin
                rd(4'(a), rv); chk("R8 read zero", rv, 0);
            end
        end
        idle_check_outputs("R7 final");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule